// File: doc/BRIEF.md
# Paced SPI Host Byte Controller

This block is the host end of an SPI link to a slow peripheral that cannot accept bytes back to back at full speed. Each request on a valid/ready byte port becomes one 8-bit SPI exchange. The flag that comes with the request picks a write, which shifts the supplied byte out, or a read, which shifts out a filler byte and returns what the peripheral drove on MISO. Bit order, clock polarity, clock phase, the SCK half-period and two idle gaps are set at run time. One gap follows writes and the other follows reads, so each kind of byte can get the recovery time the peripheral needs.

After every byte the controller keeps SCK still and stays busy until the chosen gap has run out. An active-low pending input from the peripheral can trigger read transfers without a request when auto-read is enabled. Configuration inputs are captured only while the controller is idle. A change that arrives during a byte or its gap therefore has no effect until the next byte.

Top module: `spi_paced_host`

## Requirements
- R1: With `cfg_lsb_first`=0, data bit 7 is the first bit on MOSI and the first bit captured from MISO. With `cfg_lsb_first`=1, bit 0 comes first in both directions.
- R2: While the controller is idle, SCK settles one cycle later at the level of `cfg_cpol` (0 = low, 1 = high). It keeps that level through the whole post-byte gap.
- R3: With `cfg_cpha`=0, data is sampled on the first SCK edge of each bit and changes on the second. With `cfg_cpha`=1, data changes on the first edge and is sampled on the second.
- R4: A read (`req_rd`=1) drives 0xFF on MOSI. The byte received on MISO appears on `rx_data` in the cycle where `done` is high. A write returns its received byte the same way.
- R5: Counting from the `done` cycle, `busy` stays high for exactly the selected gap in clock cycles: `cfg_rd_gap` after reads and `cfg_wr_gap` after writes. A gap of 0 leaves `busy` low in the `done` cycle. SCK has no edge during the gap.
- R6: When `cfg_auto_rd`=1 and `pend_n`=0 while idle, the controller starts read transfers by itself and holds `req_ready` low. It starts no more of them once `pend_n` is high.
- R7: `ss_n` goes low at least one clock cycle before the first SCK edge and stays low through all 16 edges of the byte. In the `done` cycle `ss_n` equals NOT `cfg_keep_ss`: it is released when keep is 0 and held low when keep is 1.
- R8: Bit order, polarity, phase, divider, gaps and keep-select are sampled when a byte starts. Changes to them while `busy` is high do not affect that byte or its gap.
- R9: Every SCK half-period lasts `cfg_half_div` clock cycles, and a value of 0 acts as 1.
- R10: `done` is a single-cycle pulse, one per byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lsb_first | input | 1 | 1 = LSB first, 0 = MSB first |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0 = sample on first edge, 1 = on second edge |
| cfg_keep_ss | input | 1 | Keep slave select low between bytes |
| cfg_auto_rd | input | 1 | Enable reads triggered by `pend_n` |
| cfg_half_div | input | DIV_W | SCK half-period in clock cycles |
| cfg_wr_gap | input | GAP_W | Idle cycles after a write byte |
| cfg_rd_gap | input | GAP_W | Idle cycles after a read byte |
| req_valid | input | 1 | Byte request present |
| req_rd | input | 1 | 1 = read (send filler), 0 = write |
| req_data | input | 8 | Byte to write |
| req_ready | output | 1 | Request accepted this cycle when high together with `req_valid` |
| done | output | 1 | Byte finished pulse |
| rx_data | output | 8 | Byte received from MISO |
| busy | output | 1 | Byte or post-byte gap in progress |
| pend_n | input | 1 | Peripheral has data waiting, active low |
| sck | output | 1 | SPI clock |
| ss_n | output | 1 | Slave select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Several properties are checked on every clock cycle. SCK keeps its idle level and stays still during a gap. Every SCK edge that belongs to a byte happens with slave select low. The captured mode stays frozen while a byte is active. `done` never lasts longer than one cycle, and `req_ready` is never high while the controller is busy. Some behaviour can only be shown by the bench scenarios, which drive a peripheral model. These are the correct bit order and phase in both directions, the exact length of each gap, the half-period length, and the pending-driven reads that stop when `pend_n` rises. The bench also shows that a configuration change made in the middle of a byte leaves that byte unchanged.

// File: rtl/spi_ph_pkg.sv
package spi_ph_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_GAP  = 2'd2
  } st_t;

  typedef struct packed {
    logic lsb;
    logic cpol;
    logic cpha;
    logic keep_ss;
  } mode_t;

endpackage

// File: rtl/spi_ph_cnt.sv
// Loadable down-counter that holds at zero; used for SCK half-periods and gaps.
module spi_ph_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt;
    if (load)                 cnt_d = load_val;
    else if (en && cnt != '0) cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end
endmodule

// File: rtl/spi_ph_shift.sv
// Transmit and receive shift registers with selectable bit order.
module spi_ph_shift #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            lsb,
  input  logic            shift_tx,
  input  logic            sample,
  input  logic            miso,
  output logic            mosi,
  output logic [BITS-1:0] rx
);
  logic [BITS-1:0] tx_q, tx_d, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)          tx_d = load_data;
    else if (shift_tx) tx_d = lsb ? (tx_q >> 1) : (tx_q << 1);
    rx_d = rx;
    if (sample) rx_d = lsb ? {miso, rx[BITS-1:1]} : {rx[BITS-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx   <= '0;
    end else begin
      tx_q <= tx_d;
      rx   <= rx_d;
    end
  end

  assign mosi = lsb ? tx_q[0] : tx_q[BITS-1];
endmodule

// File: rtl/spi_paced_host.sv
module spi_paced_host #(
  parameter int DIV_W = 8,
  parameter int GAP_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_lsb_first,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_keep_ss,
  input  logic             cfg_auto_rd,
  input  logic [DIV_W-1:0] cfg_half_div,
  input  logic [GAP_W-1:0] cfg_wr_gap,
  input  logic [GAP_W-1:0] cfg_rd_gap,
  input  logic             req_valid,
  input  logic             req_rd,
  input  logic [7:0]       req_data,
  output logic             req_ready,
  output logic             done,
  output logic [7:0]       rx_data,
  output logic             busy,
  input  logic             pend_n,
  output logic             sck,
  output logic             ss_n,
  output logic             mosi,
  input  logic             miso
);
  import spi_ph_pkg::*;

  localparam int BITS  = 8;
  localparam int EDGES = 2 * BITS;
  localparam int EW    = $clog2(EDGES + 1);
  localparam logic [BITS-1:0] FILLER = '1;

  st_t              st_q, st_d;
  mode_t            mode_q, mode_live;
  logic [DIV_W-1:0] div_q;
  logic [GAP_W-1:0] wgap_q, rgap_q, gap_pick;
  logic             rd_q;
  logic [EW-1:0]    eidx_q, eidx_d;
  logic             sck_q, sck_d, ss_q, ss_d, done_q;
  logic [DIV_W-1:0] hc_cnt, hc_val;
  logic [GAP_W-1:0] gc_cnt;
  logic             idle, auto_go, start, start_rd;
  logic             tick, edge_go, sample_go, shift_go, fin, hc_load;

  function automatic logic [DIV_W-1:0] half_m1(input logic [DIV_W-1:0] d);
    return (d == '0) ? '0 : d - 1'b1;
  endfunction

  always_comb begin
    mode_live.lsb     = cfg_lsb_first;
    mode_live.cpol    = cfg_cpol;
    mode_live.cpha    = cfg_cpha;
    mode_live.keep_ss = cfg_keep_ss;
  end

  // Request arbitration: pending-driven reads win over user requests
  assign idle     = (st_q == ST_IDLE);
  assign auto_go  = idle && cfg_auto_rd && !pend_n;
  assign start    = idle && (auto_go || req_valid);
  assign start_rd = auto_go || req_rd;

  // Edge sequencing: 16 SCK edges, then one trailing half-period before done
  assign tick      = (st_q == ST_XFER) && (hc_cnt == '0);
  assign edge_go   = tick && (eidx_q != EW'(EDGES));
  assign fin       = tick && (eidx_q == EW'(EDGES));
  assign sample_go = edge_go && (eidx_q[0] == mode_q.cpha);
  assign shift_go  = edge_go && (eidx_q[0] != mode_q.cpha) && (eidx_q != '0);
  assign gap_pick  = rd_q ? rgap_q : wgap_q;

  assign hc_load = start || (tick && !fin);
  assign hc_val  = start ? half_m1(cfg_half_div) : half_m1(div_q);

  spi_ph_cnt #(.W(DIV_W)) u_half (
    .clk(clk), .rst_n(rst_n), .load(hc_load), .load_val(hc_val),
    .en(st_q == ST_XFER), .cnt(hc_cnt)
  );

  spi_ph_cnt #(.W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .load(fin), .load_val(gap_pick),
    .en(st_q == ST_GAP), .cnt(gc_cnt)
  );

  spi_ph_shift #(.BITS(BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start),
    .load_data(start_rd ? FILLER : req_data),
    .lsb(mode_q.lsb), .shift_tx(shift_go), .sample(sample_go),
    .miso(miso), .mosi(mosi), .rx(rx_data)
  );

  always_comb begin
    st_d   = st_q;
    eidx_d = eidx_q;
    sck_d  = sck_q;
    ss_d   = ss_q;
    unique case (st_q)
      ST_IDLE: begin
        sck_d = cfg_cpol;
        if (!cfg_keep_ss) ss_d = 1'b1;
        if (start) begin
          st_d   = ST_XFER;
          eidx_d = '0;
          ss_d   = 1'b0;
        end
      end
      ST_XFER: begin
        if (edge_go) begin
          sck_d  = ~sck_q;
          eidx_d = eidx_q + 1'b1;
        end
        if (fin) begin
          st_d = (gap_pick == '0) ? ST_IDLE : ST_GAP;
          ss_d = ~mode_q.keep_ss;
        end
      end
      ST_GAP: begin
        if (gc_cnt <= GAP_W'(1)) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      eidx_q <= '0;
      sck_q  <= 1'b0;
      ss_q   <= 1'b1;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      mode_q <= '0;
      div_q  <= '0;
      wgap_q <= '0;
      rgap_q <= '0;
    end else begin
      st_q   <= st_d;
      eidx_q <= eidx_d;
      sck_q  <= sck_d;
      ss_q   <= ss_d;
      done_q <= fin;
      if (start) rd_q <= start_rd;
      if (idle) begin
        mode_q <= mode_live;
        div_q  <= cfg_half_div;
        wgap_q <= cfg_wr_gap;
        rgap_q <= cfg_rd_gap;
      end
    end
  end

  assign req_ready = idle && !auto_go;
  assign busy      = !idle;
  assign done      = done_q;
  assign sck       = sck_q;
  assign ss_n      = ss_q;
endmodule

// File: rtl/spi_ph_chk.sv
module spi_ph_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic               req_ready,
  input logic               sck,
  input logic               ss_n,
  input logic               cfg_cpol,
  input spi_ph_pkg::st_t    st,
  input spi_ph_pkg::mode_t  mode_q
);
  import spi_ph_pkg::*;

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !busy && !$past(busy)) |-> (sck == $past(cfg_cpol))); // R2

  AST_EDGE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && busy && $past(busy) && (sck != $past(sck))) |-> !ss_n); // R7

  AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && st == ST_GAP) |-> $stable(sck)); // R5

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(mode_q)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy); // R6
endmodule

bind spi_paced_host spi_ph_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .req_ready(req_ready),
  .sck(sck), .ss_n(ss_n), .cfg_cpol(cfg_cpol), .st(st_q), .mode_q(mode_q)
);

// File: tb/sim_spi_paced_host.sv
`timescale 1ns/1ps
module sim_spi_paced_host;
  localparam int DIV_W = 8;
  localparam int GAP_W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_lsb_first, cfg_cpol, cfg_cpha, cfg_keep_ss, cfg_auto_rd;
  logic [DIV_W-1:0] cfg_half_div;
  logic [GAP_W-1:0] cfg_wr_gap, cfg_rd_gap;
  logic req_valid, req_rd;
  logic [7:0] req_data;
  logic req_ready, done, busy, pend_n, sck, ss_n, mosi, miso;
  logic [7:0] rx_data;

  always #2 clk = ~clk;

  spi_paced_host #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_lsb_first(cfg_lsb_first), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_keep_ss(cfg_keep_ss), .cfg_auto_rd(cfg_auto_rd),
    .cfg_half_div(cfg_half_div), .cfg_wr_gap(cfg_wr_gap), .cfg_rd_gap(cfg_rd_gap),
    .req_valid(req_valid), .req_rd(req_rd), .req_data(req_data), .req_ready(req_ready),
    .done(done), .rx_data(rx_data), .busy(busy), .pend_n(pend_n), .sck(sck),
    .ss_n(ss_n), .mosi(mosi), .miso(miso)
  );

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Peripheral model: its own copy of order and phase
  bit         slv_lsb, slv_cpha;
  logic [7:0] sbyte, srcv, sgot;
  logic [2:0] sidx;
  int         e, hp_cyc, hp_last, ss_viol, gap_meas, gap_sck_viol;
  bit         gap_on;
  logic       prev_sck;

  assign miso = slv_lsb ? sbyte[sidx] : sbyte[3'd7 - sidx];

  always @(negedge clk) begin
    if (!rst_n) begin
      e = 0; sidx = 0; hp_cyc = 0; gap_on = 0; gap_meas = 0; prev_sck = sck;
    end else begin
      hp_cyc++;
      if (ss_n && !busy) begin e = 0; sidx = 0; end
      if (done) begin gap_on = 1; gap_meas = busy ? 1 : 0; end
      else if (gap_on && busy) gap_meas++;
      else gap_on = 0;
      if (sck !== prev_sck && busy) begin
        if (ss_n) ss_viol++;
        if (gap_on) gap_sck_viol++;
        e++;
        if (e > 1) hp_last = hp_cyc;
        hp_cyc = 0;
        if ((!slv_cpha && e % 2 == 1) || (slv_cpha && e % 2 == 0)) begin
          if (slv_lsb) srcv[(e-1)/2] = mosi;
          else         srcv[7-(e-1)/2] = mosi;
        end
        if (e == 16) begin sgot = srcv; e = 0; sidx = 0; end
        else sidx = 3'(e >> 1);
      end
      prev_sck = sck;
    end
  end

  function automatic int exp_half(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int exp_gap(input bit rd, input int wg, input int rg);
    return rd ? rg : wg;
  endfunction

  task automatic setcfg(input bit lsb, input bit cpol, input bit cpha, input bit keep,
                        input int div, input int wg, input int rg);
    @(negedge clk);
    cfg_lsb_first = lsb; cfg_cpol = cpol; cfg_cpha = cpha; cfg_keep_ss = keep;
    cfg_half_div = DIV_W'(div); cfg_wr_gap = GAP_W'(wg); cfg_rd_gap = GAP_W'(rg);
    slv_lsb = lsb; slv_cpha = cpha;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer(input bit rd, input logic [7:0] d, input logic [7:0] sb, input bit disturb);
    int div0, wg0, rg0;
    bit keep0, cpol0;
    logic [7:0] got;
    div0 = int'(cfg_half_div); wg0 = int'(cfg_wr_gap); rg0 = int'(cfg_rd_gap);
    keep0 = cfg_keep_ss; cpol0 = cfg_cpol;
    sbyte = sb;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_rd = rd; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(ss_n == 1'b0 && sck == cpol0, "R7 select before first edge", {ss_n, sck}, {1'b0, cpol0});
    if (disturb) begin
      repeat (4) @(negedge clk);
      cfg_lsb_first = ~cfg_lsb_first; cfg_cpha = ~cfg_cpha; cfg_cpol = ~cfg_cpol;
      cfg_half_div = 8'd1; cfg_wr_gap = GAP_W'(wg0 + 7); cfg_rd_gap = GAP_W'(rg0 + 7);
      cfg_keep_ss = ~cfg_keep_ss;
    end
    while (!done) @(negedge clk);
    got = rx_data;
    chk(got == sb, "R4 received byte", got, sb);
    chk(ss_n == !keep0, "R7 select at done", ss_n, !keep0);
    @(negedge clk);
    chk(done == 1'b0, "R10 single pulse", done, 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(gap_meas == exp_gap(rd, wg0, rg0), disturb ? "R8 R5 gap length" : "R5 gap length",
        gap_meas, exp_gap(rd, wg0, rg0));
    chk(sgot == (rd ? 8'hFF : d), disturb ? "R8 R1 R3 MOSI byte" : "R1 R3 R4 MOSI byte",
        sgot, rd ? 8'hFF : d);
    chk(hp_last == exp_half(div0), disturb ? "R8 R9 half period" : "R9 half period",
        hp_last, exp_half(div0));
    if (disturb) begin
      cfg_lsb_first = slv_lsb; cfg_cpha = slv_cpha; cfg_cpol = cpol0;
      cfg_half_div = DIV_W'(div0); cfg_wr_gap = GAP_W'(wg0); cfg_rd_gap = GAP_W'(rg0);
      cfg_keep_ss = keep0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] sbs [3];
    int ndone;
    void'($urandom(32'd1234));
    rst_n = 1'b0; cfg_lsb_first = 0; cfg_cpol = 0; cfg_cpha = 0; cfg_keep_ss = 0;
    cfg_auto_rd = 0; cfg_half_div = 8'd1; cfg_wr_gap = '0; cfg_rd_gap = '0;
    req_valid = 0; req_rd = 0; req_data = '0; pend_n = 1'b1;
    slv_lsb = 0; slv_cpha = 0; sbyte = '0; srcv = '0; sgot = '0;
    ss_viol = 0; gap_sck_viol = 0; hp_last = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({sck, ss_n, busy, req_ready, done} == 5'b01010, "R2 R7 reset state",
        {sck, ss_n, busy, req_ready, done}, 5'b01010);

    // R2: idle level follows polarity
    setcfg(0, 1, 0, 0, 1, 0, 0);
    chk(sck == 1'b1, "R2 idle high", sck, 1);
    setcfg(0, 0, 0, 0, 1, 0, 0);
    chk(sck == 1'b0, "R2 idle low", sck, 0);

    // Directed: every order/polarity/phase combination, write then read
    for (int m = 0; m < 8; m++) begin
      setcfg(m[0], m[1], m[2], 0, 1 + m % 3, m, 6 + m);
      xfer(1'b0, 8'($urandom), 8'($urandom), 1'b0);
      xfer(1'b1, 8'h00, 8'($urandom), 1'b0);
    end

    // R9 corner: divider 0 behaves as 1; zero gaps back to back
    setcfg(1, 0, 1, 0, 0, 0, 0);
    xfer(1'b0, 8'hA5, 8'h3C, 1'b0);
    xfer(1'b1, 8'h00, 8'h81, 1'b0);

    // R7: keep select low between bytes
    setcfg(0, 1, 1, 1, 2, 3, 4);
    xfer(1'b0, 8'h12, 8'hED, 1'b0);
    chk(ss_n == 1'b0, "R7 held between bytes", ss_n, 0);
    xfer(1'b1, 8'h00, 8'h5A, 1'b0);
    setcfg(0, 1, 1, 0, 2, 3, 4);
    chk(ss_n == 1'b1, "R7 released when keep cleared", ss_n, 1);

    // R8: configuration changes in the middle of a byte are ignored
    setcfg(0, 0, 0, 0, 3, 5, 9);
    xfer(1'b0, 8'hC3, 8'h96, 1'b1);
    setcfg(1, 1, 1, 0, 2, 2, 11);
    xfer(1'b1, 8'h00, 8'h4B, 1'b1);

    // Constrained random mix
    for (int i = 0; i < 40; i++) begin
      setcfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
             int'($urandom % 5), int'($urandom % 20), int'($urandom % 20));
      xfer(1'($urandom), 8'($urandom), 8'($urandom), 1'b0);
    end

    // R6: pending-driven reads
    setcfg(0, 0, 1, 0, 1, 2, 8);
    cfg_auto_rd = 1'b1;
    for (int k = 0; k < 3; k++) sbs[k] = 8'($urandom);
    sbyte = sbs[0];
    @(negedge clk);
    pend_n = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b0 && busy == 1'b1, "R6 auto read started", {req_ready, busy}, 2'b01);
    for (int k = 0; k < 3; k++) begin
      while (!done) @(negedge clk);
      chk(rx_data == sbs[k], "R6 auto read data", rx_data, sbs[k]);
      if (k < 2) sbyte = sbs[k+1];
      else pend_n = 1'b1;
      @(negedge clk);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    chk(sgot == 8'hFF, "R6 R4 filler on MOSI", sgot, 8'hFF);
    ndone = 0;
    repeat (200) begin
      @(negedge clk);
      if (done) ndone++;
    end
    chk(ndone == 0, "R6 stops when pending released", ndone, 0);
    cfg_auto_rd = 1'b0;

    chk(ss_viol == 0, "R7 edges only while selected", ss_viol, 0);
    chk(gap_sck_viol == 0, "R5 SCK quiet in gap", gap_sck_viol, 0);

    summary();
    $finish;
  end
endmodule